// File: doc/BRIEF.md
# Program Counter Address Match Interrupt

This block watches the fetch address that a small CPU core presents and raises an interrupt request when that address equals one of two programmable 20-bit breakpoint targets. Software programs each target through a byte-wide register port, one byte per access, three bytes per target. A separate enable register switches each channel on or off. The request does not pass through the global interrupt enable flag or the priority level mask, so the block has no input for either. The core routes the request straight to its vectoring logic.

A fetch is offered with `pc_valid` and a 20-bit `pc_addr`. Each channel compares the full address against its stored target. If any enabled channel matches, a small request state machine moves from `RQ_QUIET` to `RQ_PULSE` on the next clock. In `RQ_PULSE` the machine drives a one-cycle `irq_req`, the per-channel hit vector and the winning channel number. It stays in `RQ_PULSE` only when the next fetch also matches; otherwise it returns to `RQ_QUIET`. Register writes land on the clock edge that samples them. A fetch sampled on that same edge is therefore compared with the target value held before the write.

Top module: `amatch_top`

## Requirements
- R1: After reset the enable register reads 0x00, every target byte reads 0x00, `irq_req` is 0, `irq_hit` is 0 and `irq_chan` is 0.
- R2: The enable register is at byte address 0x0009. Bit 0 enables channel 0 and bit 1 enables channel 1, with 1 meaning enabled. Bits 7:2 ignore writes and read as 0.
- R3: The channel 0 target is at 0x0010 (bits 7:0), 0x0011 (bits 15:8) and 0x0012 (bits 19:16 in the low nibble). Channel 1 uses 0x0014, 0x0015 and 0x0016 in the same way. The upper nibble of each high byte ignores writes and reads as 0.
- R4: A write takes effect at the clock edge that samples it. A read in the following cycle returns the new value. A fetch sampled on the same edge as the write is compared with the old target.
- R5: When `pc_valid` is 1 and `pc_addr` equals all 20 bits of an enabled channel's target, the next cycle shows `irq_req`=1 for exactly that cycle. That cycle also shows `irq_hit` bit i set for each matching channel i and `irq_chan` set to the channel number. A fetch that differs in any single bit, including bit 19, raises nothing. With no request, `irq_chan` is 0.
- R6: A channel whose enable bit is 0 never sets its `irq_hit` bit and never causes `irq_req`.
- R7: With `pc_valid` at 0, no request follows, whatever `pc_addr` holds.
- R8: When both channels match the same fetch, `irq_hit` is 2'b11 and `irq_chan` is 0.
- R9: Writes to byte addresses other than the seven mapped ones change no register. Reads of unmapped addresses return 0, and `bus_rdata` is 0 whenever no read is selected.
- R10: Back-to-back matching fetches give a request on each of the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the held registers |
| pc_valid | input | 1 | A new fetch address is offered this cycle |
| pc_addr | input | 20 | Fetch address (program counter) |
| irq_req | output | 1 | One-cycle match request |
| irq_hit | output | 2 | Per-channel match flags for the request |
| irq_chan | output | 1 | Number of the winning channel, lowest first |

## Verification
On every cycle the assertions check the following. A request follows a valid fetch. A hit bit implies that the channel was enabled and that its held target equalled the previous fetch address. The hit vector and the request agree, and channel 0 wins the reported number. Padding bits of the enable and high address bytes read as 0. The bench scenarios are needed for the remaining behaviour: the byte placement of targets, the old-value comparison when a write and a fetch share an edge, the near-miss on bit 19, the effect of disabling a channel, unmapped writes leaving registers untouched, and back-to-back pulses.

// File: rtl/amatch_pkg.sv
package amatch_pkg;

    parameter int unsigned PC_W   = 20;
    parameter int unsigned NUM_CH = 2;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned BUS_AW = 16;

    localparam int unsigned BYTES_PER_CH = (PC_W + DATA_W - 1) / DATA_W;
    localparam int unsigned CH_IDW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    localparam logic [BUS_AW-1:0] EN_ADDR   = BUS_AW'(16'h0009);
    localparam logic [BUS_AW-1:0] CH_BASE   = BUS_AW'(16'h0010);
    localparam logic [BUS_AW-1:0] CH_STRIDE = BUS_AW'(16'h0004);

    typedef enum logic {
        RQ_QUIET = 1'b0,
        RQ_PULSE = 1'b1
    } rq_state_e;

endpackage

// File: rtl/amatch_regs.sv
module amatch_regs
    import amatch_pkg::*;
#(
    parameter int unsigned P_PC_W   = PC_W,
    parameter int unsigned P_NUM_CH = NUM_CH,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_AW     = BUS_AW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [P_AW-1:0]              bus_addr,
    input  logic [P_DATA_W-1:0]          bus_wdata,
    output logic [P_DATA_W-1:0]          bus_rdata,
    output logic [P_NUM_CH-1:0]          en_o,
    output logic [P_NUM_CH*P_PC_W-1:0]   tgt_o
);

    localparam int unsigned NBYTE  = (P_PC_W + P_DATA_W - 1) / P_DATA_W;
    localparam int unsigned WIDE_W = NBYTE * P_DATA_W;

    logic                wr_acc;
    logic                rd_acc;
    logic [P_NUM_CH-1:0] en_q;
    logic [P_DATA_W-1:0] en_rd;
    logic [P_DATA_W-1:0] ch_rd [P_NUM_CH];

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    // enable register: only the low NUM_CH bits exist
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_acc && bus_addr == EN_ADDR) begin
            en_q <= bus_wdata[P_NUM_CH-1:0];
        end
    end

    always_comb begin
        en_rd = '0;
        en_rd[P_NUM_CH-1:0] = en_q;
    end

    assign en_o = en_q;

    generate
        for (genvar c = 0; c < P_NUM_CH; c++) begin : g_ch
            logic [P_PC_W-1:0] tgt_q;
            logic [P_PC_W-1:0] tgt_d;
            logic [WIDE_W-1:0] wide_cur;
            logic [WIDE_W-1:0] wide_nxt;
            logic [P_DATA_W-1:0] rd_byte;

            always_comb begin
                wide_cur = '0;
                wide_cur[P_PC_W-1:0] = tgt_q;
                wide_nxt = wide_cur;
                rd_byte  = '0;
                for (int b = 0; b < NBYTE; b++) begin
                    if (bus_addr == P_AW'(CH_BASE + CH_STRIDE * c + b)) begin
                        rd_byte = wide_cur[b*P_DATA_W +: P_DATA_W];
                        if (wr_acc) begin
                            wide_nxt[b*P_DATA_W +: P_DATA_W] = bus_wdata;
                        end
                    end
                end
                tgt_d = wide_nxt[P_PC_W-1:0];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tgt_q <= '0;
                end else begin
                    tgt_q <= tgt_d;
                end
            end

            assign ch_rd[c] = rd_byte;
            assign tgt_o[c*P_PC_W +: P_PC_W] = tgt_q;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (bus_addr == EN_ADDR) begin
                bus_rdata = en_rd;
            end
            for (int c = 0; c < P_NUM_CH; c++) begin
                bus_rdata = bus_rdata | ch_rd[c];
            end
        end
    end

endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp #(
    parameter int unsigned P_PC_W = 20
) (
    input  logic              fetch_vld,
    input  logic [P_PC_W-1:0] fetch_pc,
    input  logic [P_PC_W-1:0] target,
    input  logic              chan_en,
    output logic              hit
);

    logic addr_eq;

    assign addr_eq = (fetch_pc == target);
    assign hit     = fetch_vld && chan_en && addr_eq;

endmodule

// File: rtl/amatch_req_fsm.sv
module amatch_req_fsm
    import amatch_pkg::*;
#(
    parameter int unsigned P_NUM_CH = NUM_CH,
    parameter int unsigned P_IDW    = CH_IDW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_NUM_CH-1:0] hit_i,
    output logic                irq_req,
    output logic [P_NUM_CH-1:0] irq_hit,
    output logic [P_IDW-1:0]    irq_chan
);

    rq_state_e           state_q;
    rq_state_e           state_d;
    logic [P_IDW-1:0]    chan_d;
    logic [P_NUM_CH-1:0] hit_q;
    logic [P_IDW-1:0]    chan_q;

    // next-state logic
    always_comb begin
        state_d = RQ_QUIET;
        unique case (state_q)
            RQ_QUIET: state_d = (|hit_i) ? RQ_PULSE : RQ_QUIET;
            RQ_PULSE: state_d = (|hit_i) ? RQ_PULSE : RQ_QUIET;
            default:  state_d = RQ_QUIET;
        endcase
    end

    // lowest channel number wins
    always_comb begin
        chan_d = '0;
        for (int i = P_NUM_CH - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                chan_d = P_IDW'(i);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= '0;
            chan_q <= '0;
        end else begin
            hit_q  <= hit_i;
            chan_q <= chan_d;
        end
    end

    assign irq_req  = (state_q == RQ_PULSE);
    assign irq_hit  = hit_q;
    assign irq_chan = chan_q;

endmodule

// File: rtl/amatch_top.sv
module amatch_top
    import amatch_pkg::*;
#(
    parameter int unsigned P_PC_W   = PC_W,
    parameter int unsigned P_NUM_CH = NUM_CH,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_AW     = BUS_AW,
    parameter int unsigned P_IDW    = CH_IDW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [P_AW-1:0]     bus_addr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    output logic [P_DATA_W-1:0] bus_rdata,
    input  logic                pc_valid,
    input  logic [P_PC_W-1:0]   pc_addr,
    output logic                irq_req,
    output logic [P_NUM_CH-1:0] irq_hit,
    output logic [P_IDW-1:0]    irq_chan
);

    logic [P_NUM_CH-1:0]        en_w;
    logic [P_NUM_CH*P_PC_W-1:0] tgt_w;
    logic [P_NUM_CH-1:0]        hit_w;

    amatch_regs #(
        .P_PC_W  (P_PC_W),
        .P_NUM_CH(P_NUM_CH),
        .P_DATA_W(P_DATA_W),
        .P_AW    (P_AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .en_o     (en_w),
        .tgt_o    (tgt_w)
    );

    generate
        for (genvar c = 0; c < P_NUM_CH; c++) begin : g_cmp
            amatch_cmp #(.P_PC_W(P_PC_W)) u_cmp (
                .fetch_vld(pc_valid),
                .fetch_pc (pc_addr),
                .target   (tgt_w[c*P_PC_W +: P_PC_W]),
                .chan_en  (en_w[c]),
                .hit      (hit_w[c])
            );
        end
    endgenerate

    amatch_req_fsm #(
        .P_NUM_CH(P_NUM_CH),
        .P_IDW   (P_IDW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit_w),
        .irq_req (irq_req),
        .irq_hit (irq_hit),
        .irq_chan(irq_chan)
    );

endmodule

// File: rtl/amatch_chk.sv
module amatch_chk
    import amatch_pkg::*;
#(
    parameter int unsigned P_PC_W   = PC_W,
    parameter int unsigned P_NUM_CH = NUM_CH,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_AW     = BUS_AW,
    parameter int unsigned P_IDW    = CH_IDW
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [P_AW-1:0]             bus_addr,
    input logic [P_DATA_W-1:0]         bus_rdata,
    input logic                        pc_valid,
    input logic [P_PC_W-1:0]           pc_addr,
    input logic                        irq_req,
    input logic [P_NUM_CH-1:0]         irq_hit,
    input logic [P_IDW-1:0]            irq_chan,
    input logic [P_NUM_CH-1:0]         en_w,
    input logic [P_NUM_CH*P_PC_W-1:0]  tgt_w
);

    localparam int unsigned HI_BITS = P_PC_W - (((P_PC_W + P_DATA_W - 1) / P_DATA_W) - 1) * P_DATA_W;

    // R7
    req_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(pc_valid));

    // R5
    hit_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hit != '0) |-> irq_req);

    // R5
    req_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_hit != '0));

    // R8
    chan_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hit[0] |-> (irq_chan == '0));

    // R2
    en_pad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == EN_ADDR) |-> (bus_rdata[P_DATA_W-1:P_NUM_CH] == '0));

    generate
        for (genvar c = 0; c < P_NUM_CH; c++) begin : g_chk
            // R5
            hit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_hit[c] |-> ($past(pc_addr) == $past(tgt_w[c*P_PC_W +: P_PC_W])));

            // R6
            hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_hit[c] |-> $past(en_w[c]));

            if (HI_BITS < P_DATA_W) begin : g_hi
                // R3
                hi_pad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (bus_sel && !bus_wr &&
                     bus_addr == P_AW'(CH_BASE + CH_STRIDE * c + (P_PC_W - 1) / P_DATA_W))
                    |-> (bus_rdata[P_DATA_W-1:HI_BITS] == '0));
            end
        end
    endgenerate

endmodule

bind amatch_top amatch_chk #(
    .P_PC_W  (P_PC_W),
    .P_NUM_CH(P_NUM_CH),
    .P_DATA_W(P_DATA_W),
    .P_AW    (P_AW),
    .P_IDW   (P_IDW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .pc_valid (pc_valid),
    .pc_addr  (pc_addr),
    .irq_req  (irq_req),
    .irq_hit  (irq_hit),
    .irq_chan (irq_chan),
    .en_w     (en_w),
    .tgt_w    (tgt_w)
);

// File: tb/amatch_top_bench.sv
module amatch_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pc_valid = 1'b0;
    logic [19:0] pc_addr = '0;
    logic        irq_req;
    logic [1:0]  irq_hit;
    logic        irq_chan;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // reference model state
    logic [1:0]  m_en;
    logic [19:0] m_tgt [2];
    logic        m_req;
    logic [1:0]  m_hit;
    logic        m_chan;

    always #4 clk = ~clk;

    amatch_top u_amatch_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pc_valid (pc_valid),
        .pc_addr  (pc_addr),
        .irq_req  (irq_req),
        .irq_hit  (irq_hit),
        .irq_chan (irq_chan)
    );

    // behavioural model: compare uses pre-write targets, writes land afterwards
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 2'b00; m_tgt[0] = '0; m_tgt[1] = '0;
            m_req = 1'b0; m_hit = 2'b00; m_chan = 1'b0;
        end else begin
            logic [1:0] h;
            for (int i = 0; i < 2; i++)
                h[i] = pc_valid && m_en[i] && (pc_addr == m_tgt[i]);
            m_hit  = h;
            m_req  = (h != 2'b00);
            m_chan = (!h[0] && h[1]);
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    16'h0009: m_en = bus_wdata[1:0];
                    16'h0010: m_tgt[0][7:0]   = bus_wdata;
                    16'h0011: m_tgt[0][15:8]  = bus_wdata;
                    16'h0012: m_tgt[0][19:16] = bus_wdata[3:0];
                    16'h0014: m_tgt[1][7:0]   = bus_wdata;
                    16'h0015: m_tgt[1][15:8]  = bus_wdata;
                    16'h0016: m_tgt[1][19:16] = bus_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] model_rd(input logic [15:0] a);
        case (a)
            16'h0009: return {6'b0, m_en};
            16'h0010: return m_tgt[0][7:0];
            16'h0011: return m_tgt[0][15:8];
            16'h0012: return {4'b0, m_tgt[0][19:16]};
            16'h0014: return m_tgt[1][7:0];
            16'h0015: return m_tgt[1][15:8];
            16'h0016: return {4'b0, m_tgt[1][19:16]};
            default:  return 8'h00;
        endcase
    endfunction

    // per-clock comparison of request outputs (R5 R6 R7 R8 R10 via scenario tag)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (irq_req !== m_req || irq_hit !== m_hit || irq_chan !== m_chan) begin
                bad++;
                $display("FAIL %s irq: actual req=%0b hit=%b chan=%0b expected req=%0b hit=%b chan=%0b",
                         cur_tag, irq_req, irq_hit, irq_chan, m_req, m_hit, m_chan);
            end
            if (!bus_sel && bus_rdata !== 8'h00) begin
                total++; bad++;
                $display("FAIL R9 idle rdata: actual %h expected 00", bus_rdata);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        total++;
        if (bus_rdata !== exp || bus_rdata !== model_rd(a)) begin
            bad++;
            $display("FAIL %s read %h: actual %h expected %h", tag, a, bus_rdata, exp);
        end
        #1;
        bus_sel = 1'b0;
    endtask

    // offer one fetch, then check the pulse on the following cycle
    task automatic fetch(input logic [19:0] pc, input logic v, input logic ereq,
                         input logic [1:0] ehit, input logic echan, input string tag);
        @(posedge clk); #1;
        pc_valid = v; pc_addr = pc;
        @(posedge clk); #1;
        pc_valid = 1'b0;
        total++;
        if (irq_req !== ereq || irq_hit !== ehit || irq_chan !== echan) begin
            bad++;
            $display("FAIL %s fetch %h: actual req=%0b hit=%b chan=%0b expected req=%0b hit=%b chan=%0b",
                     tag, pc, irq_req, irq_hit, irq_chan, ereq, ehit, echan);
        end
        @(posedge clk); #1;
        total++;
        if (irq_req !== 1'b0) begin
            bad++;
            $display("FAIL %s pulse width: actual req=%0b expected 0", tag, irq_req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_tag = "R1";
        rd(16'h0009, 8'h00, "R1");
        rd(16'h0010, 8'h00, "R1");
        rd(16'h0012, 8'h00, "R1");
        rd(16'h0016, 8'h00, "R1");
        fetch(20'h00000, 1'b1, 1'b0, 2'b00, 1'b0, "R1");

        cur_tag = "R2";
        wr(16'h0009, 8'hFF);
        rd(16'h0009, 8'h03, "R2");

        cur_tag = "R3";
        wr(16'h0010, 8'h34); wr(16'h0011, 8'h12); wr(16'h0012, 8'hFA);
        rd(16'h0012, 8'h0A, "R3");
        rd(16'h0011, 8'h12, "R3");
        wr(16'h0014, 8'h78); wr(16'h0015, 8'h56); wr(16'h0016, 8'h33);
        rd(16'h0016, 8'h03, "R3");
        rd(16'h0014, 8'h78, "R3");

        cur_tag = "R4";
        wr(16'h0015, 8'h57);
        rd(16'h0015, 8'h57, "R4");

        cur_tag = "R5";
        fetch(20'hA1234, 1'b1, 1'b1, 2'b01, 1'b0, "R5");
        fetch(20'h21234, 1'b1, 1'b0, 2'b00, 1'b0, "R5");
        fetch(20'h35778, 1'b1, 1'b1, 2'b10, 1'b1, "R5");
        fetch(20'h35779, 1'b1, 1'b0, 2'b00, 1'b0, "R5");

        cur_tag = "R7";
        fetch(20'hA1234, 1'b0, 1'b0, 2'b00, 1'b0, "R7");

        cur_tag = "R6";
        wr(16'h0009, 8'h02);
        fetch(20'hA1234, 1'b1, 1'b0, 2'b00, 1'b0, "R6");
        fetch(20'h35778, 1'b1, 1'b1, 2'b10, 1'b1, "R6");

        cur_tag = "R8";
        wr(16'h0009, 8'h03);
        wr(16'h0014, 8'h34); wr(16'h0015, 8'h12); wr(16'h0016, 8'h0A);
        fetch(20'hA1234, 1'b1, 1'b1, 2'b11, 1'b0, "R8");

        cur_tag = "R9";
        wr(16'h0013, 8'hFF); wr(16'h0017, 8'hFF); wr(16'h000A, 8'hFF); wr(16'h0008, 8'hFF);
        rd(16'h0013, 8'h00, "R9");
        rd(16'h0017, 8'h00, "R9");
        rd(16'h0009, 8'h03, "R9");
        rd(16'h0012, 8'h0A, "R9");
        rd(16'h0016, 8'h0A, "R9");

        // R4: write and fetch on the same edge compare against the old target
        cur_tag = "R4";
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0014; bus_wdata = 8'h99;
        pc_valid = 1'b1; pc_addr = 20'hA1234;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; pc_valid = 1'b0;
        total++;
        if (irq_hit !== 2'b11) begin
            bad++;
            $display("FAIL R4 same-edge: actual hit=%b expected 11", irq_hit);
        end
        fetch(20'hA1234, 1'b1, 1'b1, 2'b01, 1'b0, "R4");

        // R10: back-to-back matching fetches
        cur_tag = "R10";
        @(posedge clk); #1;
        pc_valid = 1'b1; pc_addr = 20'hA1234;
        @(posedge clk); #1;
        pc_addr = 20'hA1299;
        total++;
        if (irq_req !== 1'b1) begin
            bad++;
            $display("FAIL R10 first pulse: actual %0b expected 1", irq_req);
        end
        @(posedge clk); #1;
        pc_valid = 1'b0;
        total++;
        if (irq_req !== 1'b1 || irq_hit !== 2'b10 || irq_chan !== 1'b1) begin
            bad++;
            $display("FAIL R10 second pulse: actual req=%0b hit=%b chan=%0b expected 1 10 1",
                     irq_req, irq_hit, irq_chan);
        end
        @(posedge clk); #1;
        total++;
        if (irq_req !== 1'b0) begin
            bad++;
            $display("FAIL R10 after: actual %0b expected 0", irq_req);
        end

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule